// File: doc/BRIEF.md
# GPIO Interrupt Routing Multiplexer

This block collects the per-pin interrupt requests of three GPIO banks and places them onto a fixed set of interrupt-controller inputs. Bank 0 has 14 pins, bank 1 has 24 pins and bank 2 has 32 pins. The controller sees 41 lines. The first 32 lines are shared. A 32-bit routing register decides, one bit per line, whether each shared line carries a pin of bank 0 or bank 1, or the pin of bank 2 with the same index. Six further lines always carry the upper pins of bank 1. The last three lines are one summary line per bank. Each summary line is the OR of that bank's pins that currently have no direct line of their own.

Software writes the routing register through a single-cycle write strobe and can read it back at any time. The routed lines and the summary lines are computed combinationally. All 41 results are then captured in a register stage before they leave the block. A change on a pin or in the routing register therefore shows at the outputs after one clock edge.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is asserted and right after it, the routing register reads 0 and all 41 interrupt lines are 0, whatever the pins do.
- R2: When `cfg_wr_en` is 1 at a rising edge, `cfg_rdata` holds the value of `cfg_wdata` from that edge onwards; with `cfg_wr_en` at 0 the register keeps its value.
- R3: Line i (0 to 13) carries bank 0 pin i when routing bit i is 0, and bank 2 pin i when routing bit i is 1.
- R4: Line 14+j (j = 0 to 17) carries bank 1 pin j when routing bit 14+j is 0, and bank 2 pin 14+j when that bit is 1.
- R5: Lines 32 to 37 carry bank 1 pins 18 to 23 in order, for any routing value.
- R6: Line 38 is the OR of the bank 0 pins i whose routing bit i is 1.
- R7: Line 39 is the OR of the bank 1 pins j below 18 whose routing bit 14+j is 1; bank 1 pins 18 to 23 never reach line 39.
- R8: Line 40 is the OR of the bank 2 pins k whose routing bit k is 0; after reset every bank 2 pin reaches only line 40.
- R9: Every line is registered once: its value after a rising edge is a function of the pins and the routing register just before that edge. A routing write therefore reaches the lines one edge after the edge that stores it.
- R10: For any routing value, each asserted pin shows on exactly one place: either its own direct line or its bank's summary line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the routing register |
| cfg_wdata | input | 32 | Routing value to store |
| cfg_rdata | output | 32 | Current routing register contents |
| bank0_irq | input | 14 | Interrupt requests of bank 0 pins |
| bank1_irq | input | 24 | Interrupt requests of bank 1 pins |
| bank2_irq | input | 32 | Interrupt requests of bank 2 pins |
| irq_lines | output | 41 | Registered interrupt-controller inputs |

## Verification
A routing write appears on `cfg_rdata` directly after the edge that stores it. The routed lines need one more edge, so the bench holds each vector's pins for two edges and samples at the falling edge after the second. The latency test samples after the first edge as well and expects the old routing there, so an extra or missing register stage is caught. Pin pulses one cycle long must show on their line during exactly one sample. The checker compares each output with the `$past` values of the ports at the preceding edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DEF_B0_PINS = 14;
  localparam int unsigned DEF_B1_PINS = 24;
  localparam int unsigned DEF_B2_PINS = 32;
  localparam int unsigned N_SUMMARY   = 3;

  // Select between the owner pin and the bank 2 pin of a shared line.
  function automatic logic pick_src(input logic sel_b2, input logic own, input logic alt);
    return sel_b2 ? alt : own;
  endfunction

  // A pin lacks a direct line when its share bit points away from it.
  function automatic logic loose_pin(input logic pin, input logic share_taken);
    return pin & share_taken;
  endfunction
endpackage

// File: rtl/gir_ctrl_reg.sv
module gir_ctrl_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
  end
endmodule

// File: rtl/gir_route.sv
module gir_route
  import gpio_irq_pkg::*;
#(
  parameter int unsigned B0_PINS = DEF_B0_PINS,
  parameter int unsigned B1_PINS = DEF_B1_PINS,
  parameter int unsigned B2_PINS = DEF_B2_PINS,
  localparam int unsigned B1_SHARED = B2_PINS - B0_PINS,
  localparam int unsigned N_DIRECT  = B0_PINS + B1_PINS
) (
  input  logic [B2_PINS-1:0]  route_sel,
  input  logic [B0_PINS-1:0]  b0,
  input  logic [B1_PINS-1:0]  b1,
  input  logic [B2_PINS-1:0]  b2,
  output logic [N_DIRECT-1:0] direct,
  output logic [B0_PINS-1:0]  b0_loose,
  output logic [B1_PINS-1:0]  b1_loose,
  output logic [B2_PINS-1:0]  b2_loose
);
  // Lines shared between bank 0 and bank 2.
  for (genvar i = 0; i < B0_PINS; i++) begin : g_b0
    assign direct[i]   = pick_src(route_sel[i], b0[i], b2[i]);
    assign b0_loose[i] = loose_pin(b0[i], route_sel[i]);
  end

  // Bank 1: lower pins share with bank 2, upper pins are always direct.
  for (genvar j = 0; j < B1_PINS; j++) begin : g_b1
    if (j < B1_SHARED) begin : g_shared
      assign direct[B0_PINS+j] = pick_src(route_sel[B0_PINS+j], b1[j], b2[B0_PINS+j]);
      assign b1_loose[j]       = loose_pin(b1[j], route_sel[B0_PINS+j]);
    end else begin : g_fixed
      assign direct[B0_PINS+j] = b1[j];
      assign b1_loose[j]       = 1'b0;
    end
  end

  // Bank 2 pins are loose unless their share bit claims the line.
  for (genvar k = 0; k < B2_PINS; k++) begin : g_b2
    assign b2_loose[k] = loose_pin(b2[k], ~route_sel[k]);
  end
endmodule

// File: rtl/gir_bank_or.sv
module gir_bank_or #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] pins,
  output logic         any
);
  assign any = |pins;
endmodule

// File: rtl/gir_out_stage.sv
module gir_out_stage #(
  parameter int unsigned W = 41
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int unsigned B0_PINS = DEF_B0_PINS,
  parameter int unsigned B1_PINS = DEF_B1_PINS,
  parameter int unsigned B2_PINS = DEF_B2_PINS,
  localparam int unsigned N_DIRECT = B0_PINS + B1_PINS,
  localparam int unsigned N_LINES  = N_DIRECT + N_SUMMARY
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [B2_PINS-1:0]  cfg_wdata,
  output logic [B2_PINS-1:0]  cfg_rdata,
  input  logic [B0_PINS-1:0]  bank0_irq,
  input  logic [B1_PINS-1:0]  bank1_irq,
  input  logic [B2_PINS-1:0]  bank2_irq,
  output logic [N_LINES-1:0]  irq_lines
);
  logic [B2_PINS-1:0]  route_sel;
  logic [N_DIRECT-1:0] direct_w;
  logic [B0_PINS-1:0]  b0_loose_w;
  logic [B1_PINS-1:0]  b1_loose_w;
  logic [B2_PINS-1:0]  b2_loose_w;
  logic [N_SUMMARY-1:0] summary_w;
  logic [N_LINES-1:0]  lines_next;

  gir_ctrl_reg #(.W(B2_PINS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata), .q(route_sel)
  );

  gir_route #(.B0_PINS(B0_PINS), .B1_PINS(B1_PINS), .B2_PINS(B2_PINS)) u_route (
    .route_sel(route_sel), .b0(bank0_irq), .b1(bank1_irq), .b2(bank2_irq),
    .direct(direct_w), .b0_loose(b0_loose_w), .b1_loose(b1_loose_w), .b2_loose(b2_loose_w)
  );

  gir_bank_or #(.W(B0_PINS)) u_or0 (.pins(b0_loose_w), .any(summary_w[0]));
  gir_bank_or #(.W(B1_PINS)) u_or1 (.pins(b1_loose_w), .any(summary_w[1]));
  gir_bank_or #(.W(B2_PINS)) u_or2 (.pins(b2_loose_w), .any(summary_w[2]));

  assign lines_next = {summary_w, direct_w};

  gir_out_stage #(.W(N_LINES)) u_out (
    .clk(clk), .rst_n(rst_n), .d(lines_next), .q(irq_lines)
  );

  assign cfg_rdata = route_sel;
endmodule

// File: rtl/gir_checker.sv
module gir_checker #(
  parameter int unsigned B0_PINS = 14,
  parameter int unsigned B1_PINS = 24,
  parameter int unsigned B2_PINS = 32,
  localparam int unsigned B1S      = B2_PINS - B0_PINS,
  localparam int unsigned N_DIRECT = B0_PINS + B1_PINS,
  localparam int unsigned N_LINES  = N_DIRECT + 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr_en,
  input logic [B2_PINS-1:0] cfg_wdata,
  input logic [B2_PINS-1:0] cfg_rdata,
  input logic [B0_PINS-1:0] bank0_irq,
  input logic [B1_PINS-1:0] bank1_irq,
  input logic [B2_PINS-1:0] bank2_irq,
  input logic [N_LINES-1:0] irq_lines
);
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rdata == $past(cfg_wdata));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(cfg_rdata));

  // R3 and R4: shared lines follow the routing bits of the previous cycle (R9).
  p_shared_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_lines[B2_PINS-1:0] ==
      (($past(cfg_rdata) & $past(bank2_irq)) |
       (~$past(cfg_rdata) & $past({bank1_irq[B1S-1:0], bank0_irq}))));

  p_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_lines[N_DIRECT-1:B2_PINS] == $past(bank1_irq[B1_PINS-1:B1S]));

  p_sum0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_lines[N_DIRECT] == |($past(bank0_irq) & $past(cfg_rdata[B0_PINS-1:0])));

  p_sum1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_lines[N_DIRECT+1] ==
      |($past(bank1_irq[B1S-1:0]) & $past(cfg_rdata[B2_PINS-1:B0_PINS])));

  p_sum2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_lines[N_DIRECT+2] == |($past(bank2_irq) & ~$past(cfg_rdata)));
endmodule

bind gpio_irq_router gir_checker #(
  .B0_PINS(B0_PINS), .B1_PINS(B1_PINS), .B2_PINS(B2_PINS)
) u_chk (.*);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int NV = 6;
  localparam logic [31:0] V_CTRL [NV] = '{32'h0, 32'hFFFF_FFFF, 32'h0000_3FFF,
                                         32'hFFFF_C000, 32'hA5A5_5A5A, 32'h0000_0001};
  localparam logic [13:0] V_B0 [NV] = '{14'h3FFF, 14'h0001, 14'h2AAA, 14'h0000, 14'h1234, 14'h0001};
  localparam logic [23:0] V_B1 [NV] = '{24'hFC_0000, 24'h03_FFFF, 24'h00_0000, 24'h02_0001, 24'hABCDEF, 24'h00_0000};
  localparam logic [31:0] V_B2 [NV] = '{32'h8000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_C000, 32'h1357_9BDF, 32'h0000_0002};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr_en = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [13:0] bank0_irq = '0;
  logic [23:0] bank1_irq = '0;
  logic [31:0] bank2_irq = '0;
  logic [40:0] irq_lines;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_router u_dut (.*);

  // Bench model: walks each output line and names its source.
  function automatic logic [40:0] model(input logic [31:0] c, input logic [13:0] a,
                                        input logic [23:0] b, input logic [31:0] d);
    logic [40:0] r = '0;
    for (int n = 0; n < 32; n++) begin
      if (c[n]) r[n] = d[n];
      else if (n < 14) r[n] = a[n];
      else r[n] = b[n-14];
    end
    for (int n = 32; n < 38; n++) r[n] = b[n-14];
    for (int n = 0; n < 14; n++) if (c[n] && a[n]) r[38] = 1'b1;
    for (int n = 0; n < 18; n++) if (c[n+14] && b[n]) r[39] = 1'b1;
    for (int n = 0; n < 32; n++) if (!c[n] && d[n]) r[40] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // R10: every asserted pin lands on its direct line or its summary line.
  task automatic cover_pins(input logic [31:0] c, input logic [13:0] a,
                            input logic [23:0] b, input logic [31:0] d);
    int miss = 0;
    for (int n = 0; n < 14; n++)
      if (a[n] && !(c[n] ? irq_lines[38] : irq_lines[n])) miss++;
    for (int n = 0; n < 24; n++)
      if (b[n] && !((n < 18 && c[n+14]) ? irq_lines[39] : irq_lines[n+14])) miss++;
    for (int n = 0; n < 32; n++)
      if (d[n] && !(c[n] ? irq_lines[n] : irq_lines[40])) miss++;
    chk("R10", 64'(miss), 64'd0);
  endtask

  task automatic apply(input logic [31:0] c, input logic [13:0] a,
                       input logic [23:0] b, input logic [31:0] d);
    logic [40:0] e;
    cfg_wr_en = 1; cfg_wdata = c; bank0_irq = a; bank1_irq = b; bank2_irq = d;
    tick();
    cfg_wr_en = 0;
    chk("R2", 64'(cfg_rdata), 64'(c));
    tick();
    e = model(c, a, b, d);
    chk("R3", 64'(irq_lines[13:0]), 64'(e[13:0]));
    chk("R4", 64'(irq_lines[31:14]), 64'(e[31:14]));
    chk("R5", 64'(irq_lines[37:32]), 64'(b[23:18]));
    chk("R6", 64'(irq_lines[38]), 64'(e[38]));
    chk("R7", 64'(irq_lines[39]), 64'(e[39]));
    chk("R8", 64'(irq_lines[40]), 64'(e[40]));
    cover_pins(c, a, b, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: pins active during reset do not reach the lines.
    bank0_irq = '1; bank1_irq = '1; bank2_irq = '1;
    cfg_wr_en = 1; cfg_wdata = '1;
    repeat (3) tick();
    chk("R1 lines", 64'(irq_lines), 64'd0);
    chk("R1 cfg", 64'(cfg_rdata), 64'd0);
    cfg_wr_en = 0; bank0_irq = '0; bank1_irq = '0; bank2_irq = '0;
    rst_n = 1;
    tick();
    chk("R1 after release", 64'(irq_lines), 64'd0);
    chk("R1 cfg after release", 64'(cfg_rdata), 64'd0);

    // R8: default routing sends a bank 2 pin only to line 40.
    bank2_irq = 32'h0000_0100;
    tick();
    chk("R8 default", 64'(irq_lines), 64'(41'h1 << 40));
    bank2_irq = '0;

    for (int v = 0; v < NV; v++) apply(V_CTRL[v], V_B0[v], V_B1[v], V_B2[v]);

    // R2: no strobe, no change.
    cfg_wdata = 32'hDEAD_BEEF;
    tick();
    chk("R2 hold", 64'(cfg_rdata), 64'(V_CTRL[NV-1]));

    // R9: routing write reaches the lines one edge after it is stored.
    apply(32'h0, 14'h3FFF, 24'h0, 32'h0);
    cfg_wr_en = 1; cfg_wdata = '1;
    tick();
    cfg_wr_en = 0;
    chk("R9 old routing", 64'(irq_lines), 64'(41'h3FFF));
    tick();
    chk("R9 new routing", 64'(irq_lines), 64'(41'h1 << 38));

    // R9 and R5: one-cycle pin pulse shows for exactly one sample.
    bank0_irq = '0;
    tick();
    bank1_irq = 24'h10_0000;
    tick();
    chk("R5 pulse on", 64'(irq_lines), 64'(41'h1 << 34));
    bank1_irq = '0;
    tick();
    chk("R9 pulse off", 64'(irq_lines), 64'd0);

    // R10 and R3-R8 with random routing and pins.
    for (int r = 0; r < 24; r++)
      apply($urandom(), 14'($urandom()), 24'($urandom()), $urandom());

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule